// File: doc/BRIEF.md
# Dynamic 16/32-bit Bus Sizing Unit

This unit converts one 32-bit transfer request from a master into one or two cycles on an external 32-bit data bus. Each cycle can be answered either by a full-width slave or by a 16-bit slave. A 16-bit slave announces itself by raising a per-cycle narrow-port input together with ready. The unit reads the byte enables of the request and the narrow-port answer, and chooses among three actions:
- finish in a single cycle;
- take the upper read bytes from the low data lane;
- split the transfer into two 16-bit cycles.

Whenever only upper bytes are written, it copies the upper write half onto the low lane. Because of this, a 16-bit slave can take such a write without a second cycle.

A request is accepted on any clock edge where `req_valid` is high and no bus cycle is open. Wait states are added by holding `bus_rdy` low. When the last bus cycle of a transfer ends, the unit pulses `done` with the assembled read word on `rdata`.

Top module: `bus_sizer`

## Requirements
- R1: While reset is held and right after it, `bus_cyc`, `bus_doe` and `done` are 0 and `bus_be_n` is all ones (every byte enable negated).
- R2: A request is taken on an edge where `req_valid`=1 and `bus_cyc`=0. In the next cycle `bus_cyc`=1 and `bus_addr`, `bus_be_n` and `bus_wr` equal the request. With a full-width answer (`bus_narrow`=0 at the ready edge) there is one bus cycle. In the cycle after the ready edge, `done`=1 for exactly one cycle, `rdata` equals the whole `bus_din`, and `bus_cyc`=0.
- R3: While `bus_rdy`=0 the open cycle is extended, and `bus_addr`, `bus_be_n` and `bus_dout` stay unchanged.
- R4: When only enables 2/3 are active (`bus_be_n[1:0]`=2'b11 and `bus_be_n[3:2]`≠2'b11) on a write, `bus_dout` = {wdata[31:16], wdata[31:16]}. The write ends after one cycle even when `bus_narrow`=1.
- R5: On an upper-only read answered with `bus_narrow`=1, `rdata` = {bus_din[15:0], 16'h0000}. Bits 31:16 of `bus_din` are ignored.
- R6: On a read with enables active in both halves and answered with `bus_narrow`=1, a second cycle follows. `rdata` = {second bus_din[15:0], first bus_din[15:0]}. `bus_din[31:16]` is ignored in both cycles.
- R7: In the second cycle of a split transfer, `bus_be_n[1:0]`=2'b11, `bus_be_n[3:2]` keeps its requested value, and `bus_addr` is unchanged.
- R8: On a split write, the first cycle drives the full `wdata` on `bus_dout`. The second cycle drives {wdata[31:16], wdata[31:16]}. `bus_doe`=1 in both cycles, and `done` follows only the second ready edge.
- R9: A transfer with only enables 0/1 active (`bus_be_n[3:2]`=2'b11) always ends after one cycle. With `bus_narrow`=1 its `rdata` is {16'h0000, bus_din[15:0]}.
- R10: A request presented while `bus_cyc`=1 is ignored: the open cycle's address, enables and data are not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_be_n | input | DATA_W/8 | Active-low byte enables |
| req_wdata | input | DATA_W | Write data |
| bus_cyc | output | 1 | Bus cycle open (also busy) |
| bus_wr | output | 1 | Bus cycle direction |
| bus_addr | output | ADDR_W | Bus word address |
| bus_be_n | output | DATA_W/8 | Bus byte enables, active low |
| bus_dout | output | DATA_W | Bus write data |
| bus_doe | output | 1 | Write data driver enable |
| bus_din | input | DATA_W | Bus read data |
| bus_rdy | input | 1 | Ready, ends the current bus cycle |
| bus_narrow | input | 1 | Slave is 16 bits wide, sampled with ready |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rdata | output | DATA_W | Assembled read data, valid with done |

## Verification
All outputs are registered. Bus address, enables and write data are due in the cycle after the accepting edge. `done` and `rdata` are due in the cycle after the final ready edge. Second-cycle enables and data are due in the cycle after the first ready edge. The bench drives every input on the falling edge and samples outputs at the following falling edge, so each check lands exactly one register stage after its cause. Wait-state checks sample once per stalled cycle, and `done` is checked again one cycle later to confirm it is a single pulse.

// File: rtl/bsz_pkg.sv
package bsz_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } bsz_state_e;
endpackage

// File: rtl/bsz_lane_mux.sv
// Write-lane formatting: copies the upper half onto the lower lane when the
// lower lane carries no enabled byte of its own, or on a second split cycle.
module bsz_lane_mux #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W/8-1:0] be_n,
  input  logic                second,
  output logic [DATA_W-1:0]   lane
);
  localparam int HALF = DATA_W / 2;
  localparam int BE_W = DATA_W / 8;
  localparam int HB   = BE_W / 2;

  logic lo_used, hi_used, dup;

  always_comb begin
    lo_used = ~&be_n[HB-1:0];
    hi_used = ~&be_n[BE_W-1:HB];
    dup     = second | (hi_used & ~lo_used);
    lane    = dup ? {wdata[DATA_W-1:HALF], wdata[DATA_W-1:HALF]} : wdata;
  end
endmodule

// File: rtl/bsz_rd_assemble.sv
// Read-word assembly: keeps the first 16-bit half of a split read and
// builds the final word on the last ready edge.
module bsz_rd_assemble #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_lo,
  input  logic              finish,
  input  logic              is_second,
  input  logic              narrow,
  input  logic              hi_used,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] rdata
);
  localparam int HALF = DATA_W / 2;

  logic [HALF-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q  <= '0;
      rdata <= '0;
    end else begin
      if (cap_lo) lo_q <= din[HALF-1:0];
      if (finish) begin
        if (is_second)      rdata <= {din[HALF-1:0], lo_q};
        else if (!narrow)   rdata <= din;
        else if (hi_used)   rdata <= {din[HALF-1:0], {HALF{1'b0}}};
        else                rdata <= {{HALF{1'b0}}, din[HALF-1:0]};
      end
    end
  end
endmodule

// File: rtl/bus_sizer.sv
module bus_sizer
  import bsz_pkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W/8-1:0] req_be_n,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                bus_cyc,
  output logic                bus_wr,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [DATA_W/8-1:0] bus_be_n,
  output logic [DATA_W-1:0]   bus_dout,
  output logic                bus_doe,
  input  logic [DATA_W-1:0]   bus_din,
  input  logic                bus_rdy,
  input  logic                bus_narrow,
  output logic                done,
  output logic [DATA_W-1:0]   rdata
);
  localparam int BE_W = DATA_W / 8;
  localparam int HB   = BE_W / 2;

  bsz_state_e        state;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] first_lane, second_lane;
  logic              lo_used, hi_used, split, fin_first, fin_second;

  always_comb begin
    lo_used    = ~&bus_be_n[HB-1:0];
    hi_used    = ~&bus_be_n[BE_W-1:HB];
    split      = (state == ST_FIRST) && bus_rdy && bus_narrow && lo_used && hi_used;
    fin_first  = (state == ST_FIRST) && bus_rdy && !split;
    fin_second = (state == ST_SECOND) && bus_rdy;
  end

  bsz_lane_mux #(.DATA_W(DATA_W)) u_lane_first (
    .wdata(req_wdata), .be_n(req_be_n), .second(1'b0), .lane(first_lane)
  );

  bsz_lane_mux #(.DATA_W(DATA_W)) u_lane_second (
    .wdata(wdata_q), .be_n(bus_be_n), .second(1'b1), .lane(second_lane)
  );

  bsz_rd_assemble #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .cap_lo(split), .finish(fin_first | fin_second),
    .is_second(state == ST_SECOND), .narrow(bus_narrow), .hi_used(hi_used),
    .din(bus_din), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bus_cyc  <= 1'b0;
      bus_wr   <= 1'b0;
      bus_addr <= '0;
      bus_be_n <= '1;
      bus_dout <= '0;
      bus_doe  <= 1'b0;
      wdata_q  <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            state    <= ST_FIRST;
            bus_cyc  <= 1'b1;
            bus_wr   <= req_write;
            bus_addr <= req_addr;
            bus_be_n <= req_be_n;
            bus_dout <= first_lane;
            bus_doe  <= req_write;
            wdata_q  <= req_wdata;
          end
        end
        ST_FIRST, ST_SECOND: begin
          if (split) begin
            state    <= ST_SECOND;
            bus_be_n <= {bus_be_n[BE_W-1:HB], {HB{1'b1}}};
            bus_dout <= second_lane;
          end else if (fin_first || fin_second) begin
            state    <= ST_IDLE;
            bus_cyc  <= 1'b0;
            bus_wr   <= 1'b0;
            bus_be_n <= '1;
            bus_doe  <= 1'b0;
            done     <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: a stalled cycle keeps its address, enables and data
  p_hold_wait_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && !bus_rdy) |=> ($stable(bus_addr) && $stable(bus_be_n) && $stable(bus_dout)));

  // R4: upper-only write carries the upper half on the low lane
  p_upper_dup_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && bus_wr && &bus_be_n[HB-1:0]) |->
      (bus_dout[DATA_W/2-1:0] == bus_dout[DATA_W-1:DATA_W/2]));

  // R7: second split cycle has the lower enables negated and the same address
  p_second_lo_off_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SECOND) |-> (&bus_be_n[HB-1:0] && bus_cyc));
  p_second_addr_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(state == ST_SECOND) |-> $stable(bus_addr));

  // R2: done only after a ready edge on an open cycle, and lasts one cycle
  p_done_after_rdy_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(bus_cyc && bus_rdy));
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: lower-only transfer closes on its first ready edge
  p_lower_single_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && bus_rdy && &bus_be_n[BE_W-1:HB]) |=> !bus_cyc);

  // R10: no new request opens over a running cycle
  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && !bus_rdy && req_valid) |=> (bus_cyc && $stable(bus_addr)));
endmodule

// File: tb/bus_sizer_bench.sv
module bus_sizer_bench;
  localparam int AW = 30;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [3:0]    req_be_n = 4'hF;
  logic [DW-1:0] req_wdata = '0;
  logic          bus_cyc, bus_wr, bus_doe, done;
  logic [AW-1:0] bus_addr;
  logic [3:0]    bus_be_n;
  logic [DW-1:0] bus_dout, rdata;
  logic [DW-1:0] bus_din = '0;
  logic          bus_rdy = 1'b0, bus_narrow = 1'b0;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bus_sizer #(.ADDR_W(AW), .DATA_W(DW)) u_bus_sizer (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be_n(req_be_n), .req_wdata(req_wdata),
    .bus_cyc(bus_cyc), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be_n(bus_be_n),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din), .bus_rdy(bus_rdy),
    .bus_narrow(bus_narrow), .done(done), .rdata(rdata)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called right after a falling edge; returns one falling edge later
  task automatic issue(input logic wr, input logic [AW-1:0] a, input logic [3:0] be,
                       input logic [DW-1:0] wd);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_be_n = be; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic ready(input logic nar, input logic [DW-1:0] d);
    bus_rdy = 1'b1; bus_narrow = nar; bus_din = d;
    @(negedge clk);
    bus_rdy = 1'b0; bus_narrow = 1'b0; bus_din = 32'h0BAD_0BAD;
  endtask

  task automatic t_reset;
    chk("R1 cyc", bus_cyc, 0);
    chk("R1 be_n", bus_be_n, 4'hF);
    chk("R1 doe", bus_doe, 0);
    chk("R1 done", done, 0);
  endtask

  task automatic t_full_read;
    issue(1'b0, 30'h0123_4567, 4'b0000, '0);
    chk("R2 cyc", bus_cyc, 1);
    chk("R2 addr", bus_addr, 30'h0123_4567);
    chk("R2 be_n", bus_be_n, 4'b0000);
    chk("R2 wr", bus_wr, 0);
    ready(1'b0, 32'hA1B2_C3D4);
    chk("R2 done", done, 1);
    chk("R2 rdata", rdata, 32'hA1B2_C3D4);
    chk("R2 cyc end", bus_cyc, 0);
    @(negedge clk);
    chk("R2 done pulse", done, 0);
  endtask

  task automatic t_wait_write;
    issue(1'b1, 30'h0000_0AB0, 4'b0000, 32'h1357_9BDF);
    chk("R2 wdata", bus_dout, 32'h1357_9BDF);
    chk("R2 doe", bus_doe, 1);
    for (int i = 0; i < 3; i++) begin
      req_valid = 1'b1; req_addr = 30'h0000_0FFF; req_be_n = 4'b1100;
      @(negedge clk);
      chk("R3 addr hold", bus_addr, 30'h0000_0AB0);
      chk("R3 dout hold", bus_dout, 32'h1357_9BDF);
      chk("R10 be_n kept", bus_be_n, 4'b0000);
      chk("R3 no done", done, 0);
    end
    req_valid = 1'b0;
    ready(1'b0, '0);
    chk("R2 write done", done, 1);
    chk("R1 doe off", bus_doe, 0);
    chk("R10 no reopen", bus_cyc, 0);
  endtask

  task automatic t_upper_write;
    issue(1'b1, 30'h10, 4'b0011, 32'h1234_5678);
    chk("R4 dup", bus_dout, 32'h1234_1234);
    ready(1'b1, '0);
    chk("R4 single done", done, 1);
    chk("R4 closed", bus_cyc, 0);
  endtask

  task automatic t_upper_read;
    issue(1'b0, 30'h11, 4'b0111, '0);
    ready(1'b1, 32'hFFFF_5AA5);
    chk("R5 done", done, 1);
    chk("R5 rdata", rdata, 32'h5AA5_0000);
  endtask

  task automatic t_split_read;
    issue(1'b0, 30'h22, 4'b0000, '0);
    ready(1'b1, 32'hDEAD_1111);
    chk("R6 no done", done, 0);
    chk("R6 still open", bus_cyc, 1);
    chk("R7 be_n", bus_be_n, 4'b0011);
    chk("R7 addr", bus_addr, 30'h22);
    @(negedge clk);
    chk("R3 be_n hold", bus_be_n, 4'b0011);
    ready(1'b1, 32'hBEEF_2222);
    chk("R6 done", done, 1);
    chk("R6 rdata", rdata, 32'h2222_1111);
  endtask

  task automatic t_split_write;
    issue(1'b1, 30'h33, 4'b0100, 32'hCAFE_F00D);
    chk("R8 first", bus_dout, 32'hCAFE_F00D);
    ready(1'b1, '0);
    chk("R8 second", bus_dout, 32'hCAFE_CAFE);
    chk("R7 be_n keep", bus_be_n, 4'b0111);
    chk("R8 doe", bus_doe, 1);
    chk("R8 no done", done, 0);
    ready(1'b1, '0);
    chk("R8 done", done, 1);
  endtask

  task automatic t_lower;
    issue(1'b0, 30'h44, 4'b1100, '0);
    ready(1'b1, 32'h9999_7777);
    chk("R9 done", done, 1);
    chk("R9 rdata narrow", rdata, 32'h0000_7777);
    issue(1'b0, 30'h45, 4'b1110, '0);
    ready(1'b0, 32'h9999_7777);
    chk("R9 rdata wide", rdata, 32'h9999_7777);
    issue(1'b1, 30'h46, 4'b1101, 32'hAAAA_BBBB);
    chk("R9 wdata", bus_dout, 32'hAAAA_BBBB);
    ready(1'b1, '0);
    chk("R9 write single", done, 1);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_full_read();
    t_wait_write();
    t_upper_write();
    t_upper_read();
    t_split_read();
    t_split_write();
    t_lower();
    repeat (2) @(negedge clk);
    summary();
  end
endmodule